// File: doc/BRIEF.md
# Retimed Registered-Address RAM Wrapper

This wrapper gives its user a memory that appears to have a combinational read. The read location is named by an address register. The storage itself is a synchronous-read array, which is the cheap kind on most silicon.

The address register belongs to the wrapper and has three controls: a data input, a clock enable and a synchronous clear. Each bit of the register is built either as a reset-type bit, which clears to 0, or as a set-type bit, which clears to 1. The wrapper works out the register's next value combinationally, one small mux per bit, from that bit's data input and the clear. That next value addresses the synchronous array in the same cycle the register loads it. When the array output register updates, it therefore holds the word at the address the register has just taken. Read data lines up with the registered address and no cycle is added.

A path parameter selects the read path for the instance:
- `RD_RETIMED` is the retimed path described above.
- `RD_COMBO` is a fallback with a plain combinational read, indexed by the registered address. It is meant for a build where the address is not fully registered.

The block has no state machine. Its only sequential elements are the address register, the array output register and the storage.

Top module: `rrr_ram`

## Requirements
- R1: While `rst_n` is low, each clock edge loads the address register with `CLR_VAL`. The next read is performed at that address.
- R2: With `rst_n` high, `addr_ce` high and the clear inactive, the edge loads `rd_addr` with `addr_d`.
- R3: With `addr_ce` high and `addr_clr` equal to `CLR_ACTIVE`, bit i of `rd_addr` becomes `CLR_VAL[i]`. A bit with `CLR_VAL[i]`=1 is set-type; a bit with `CLR_VAL[i]`=0 is reset-type.
- R4: With `addr_ce` low, `rd_addr` keeps its value and the clear has no effect.
- R5: After every edge, `rd_data` equals the stored word at the current `rd_addr`, counting every write up to and including that edge. No latency is added beyond the address register.
- R6: If a write targets the address being loaded into `rd_addr` at the same edge, `rd_data` shows the new word (write-first).
- R7: If a write targets the held `rd_addr` while `addr_ce` is low, `rd_data` shows the new word after that edge.
- R8: With `PATH`=`RD_COMBO`, the observable `rd_addr` and `rd_data` behaviour is identical to that of the retimed path.
- R9: A cycle with `wr_en` low changes no stored word.
- R10: The write port works regardless of `rst_n`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset of the address register |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | AW | Write location |
| wr_data | input | DW | Write word |
| addr_d | input | AW | Data input of the address register |
| addr_ce | input | 1 | Clock enable of the address register; also the array read enable |
| addr_clr | input | 1 | Synchronous clear of the address register, active level `CLR_ACTIVE` |
| rd_addr | output | AW | Registered read address |
| rd_data | output | DW | Word stored at `rd_addr` |

## Verification
The bench builds two instances with `AW`=4, `DW`=8, `CLR_VAL`=4'b1010 and an active-high clear. One instance uses the retimed path and the other the combinational fallback, and both are compared against one behavioural model. The mixed clear value exercises set-type and reset-type bit muxes side by side. Sixteen locations keep same-address collisions frequent under random traffic, both at a load and during a stall.

// File: rtl/rrr_pkg.sv
package rrr_pkg;

    typedef enum logic {
        RD_COMBO   = 1'b0,
        RD_RETIMED = 1'b1
    } rd_path_e;

endpackage

// File: rtl/rrr_addr_reg.sv
module rrr_addr_reg #(
    parameter int             AW         = 4,
    parameter logic [AW-1:0]  CLR_VAL    = '0,
    parameter logic           CLR_ACTIVE = 1'b1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ce,
    input  logic          clr,
    input  logic [AW-1:0] d,
    output logic [AW-1:0] q,
    output logic [AW-1:0] nxt
);

    logic          clr_on;
    logic [AW-1:0] load_val;

    assign clr_on = (clr == CLR_ACTIVE);

    // one next-value mux per bit, its kind chosen by the clear value
    for (genvar i = 0; i < AW; i++) begin : g_bit
        if (CLR_VAL[i]) begin : g_set
            assign load_val[i] = clr_on | d[i];
        end else begin : g_rst
            assign load_val[i] = ~clr_on & d[i];
        end
    end

    always_comb begin
        if (!rst_n)  nxt = CLR_VAL;
        else if (ce) nxt = load_val;
        else         nxt = q;
    end

    always_ff @(posedge clk) begin
        q <= nxt;
    end

    AST_ADDR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (ce && !clr_on) |=> (q == $past(d)));                  // R2
    AST_ADDR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (ce && clr_on) |=> (q == CLR_VAL));                    // R3
    AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !ce |=> $stable(q));                                   // R4

endmodule

// File: rtl/rrr_sync_array.sv
module rrr_sync_array #(
    parameter int AW = 4,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ren,
    input  logic [AW-1:0] raddr,
    input  logic [AW-1:0] cur_addr,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] dout
);

    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] store [DEPTH];
    logic          hit_new;
    logic          hit_held;

    assign hit_new  = we && (waddr == raddr);
    assign hit_held = we && (waddr == cur_addr);

    always_ff @(posedge clk) begin
        if (we) store[waddr] <= wdata;
        if (ren) begin
            dout <= hit_new ? wdata : store[raddr];
        end else if (hit_held) begin
            dout <= wdata;
        end
    end

    AST_WRITE_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (ren && we && waddr == raddr) |=> (dout == $past(wdata)));     // R6
    AST_STALL_BYPASS: assert property (@(posedge clk) disable iff (!rst_n)
        (!ren && we && waddr == cur_addr) |=> (dout == $past(wdata))); // R7
    AST_STALL_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!ren && !(we && waddr == cur_addr)) |=> $stable(dout));       // R9

endmodule

// File: rtl/rrr_async_array.sv
module rrr_async_array #(
    parameter int AW = 4,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic [AW-1:0] raddr,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] dout
);

    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] store [DEPTH];

    always_ff @(posedge clk) begin
        if (we) store[waddr] <= wdata;
    end

    assign dout = store[raddr];

endmodule

// File: rtl/rrr_ram.sv
module rrr_ram
    import rrr_pkg::*;
#(
    parameter int             AW         = 4,
    parameter int             DW         = 8,
    parameter logic [AW-1:0]  CLR_VAL    = '0,
    parameter logic           CLR_ACTIVE = 1'b1,
    parameter rd_path_e       PATH       = RD_RETIMED
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic [AW-1:0] addr_d,
    input  logic          addr_ce,
    input  logic          addr_clr,
    output logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data
);

    logic [AW-1:0] addr_nxt;
    logic          rd_en;

    // the array read follows the address register's enable; reset forces a read
    assign rd_en = addr_ce | ~rst_n;

    rrr_addr_reg #(
        .AW         (AW),
        .CLR_VAL    (CLR_VAL),
        .CLR_ACTIVE (CLR_ACTIVE)
    ) u_areg (
        .clk   (clk),
        .rst_n (rst_n),
        .ce    (addr_ce),
        .clr   (addr_clr),
        .d     (addr_d),
        .q     (rd_addr),
        .nxt   (addr_nxt)
    );

    if (PATH == RD_RETIMED) begin : g_retimed
        rrr_sync_array #(.AW(AW), .DW(DW)) u_arr (
            .clk      (clk),
            .rst_n    (rst_n),
            .ren      (rd_en),
            .raddr    (addr_nxt),
            .cur_addr (rd_addr),
            .we       (wr_en),
            .waddr    (wr_addr),
            .wdata    (wr_data),
            .dout     (rd_data)
        );
    end else begin : g_combo
        rrr_async_array #(.AW(AW), .DW(DW)) u_arr (
            .clk   (clk),
            .raddr (rd_addr),
            .we    (wr_en),
            .waddr (wr_addr),
            .wdata (wr_data),
            .dout  (rd_data)
        );
    end

    AST_RESET_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && $past(!rst_n)) |-> (rd_addr == CLR_VAL));   // R1

endmodule

// File: tb/rrr_ram_bench.sv
module rrr_ram_bench;
    import rrr_pkg::*;

    localparam int            CLK_PERIOD = 10;
    localparam int            AW         = 4;
    localparam int            DW         = 8;
    localparam int            DEPTH      = 1 << AW;
    localparam logic [AW-1:0] CV         = 4'b1010;

    typedef struct {
        logic [AW-1:0] a;
        logic [DW-1:0] d;
        logic          chk;
        string         tag;
        string         note;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst_n, wr_en, addr_ce, addr_clr;
    logic [AW-1:0] wr_addr, addr_d;
    logic [DW-1:0] wr_data;
    logic [AW-1:0] rd_addr, fb_addr;
    logic [DW-1:0] rd_data, fb_data;

    logic [DW-1:0] mref  [DEPTH];
    logic          known [DEPTH];
    logic [AW-1:0] aref;
    exp_t          exp_q[$];
    int            n_chk  = 0;
    int            n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rrr_ram #(.AW(AW), .DW(DW), .CLR_VAL(CV), .CLR_ACTIVE(1'b1), .PATH(RD_RETIMED)) u_rrr_ram (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .addr_d(addr_d), .addr_ce(addr_ce), .addr_clr(addr_clr),
        .rd_addr(rd_addr), .rd_data(rd_data));

    rrr_ram #(.AW(AW), .DW(DW), .CLR_VAL(CV), .CLR_ACTIVE(1'b1), .PATH(RD_COMBO)) u_rrr_ram_fb (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .addr_d(addr_d), .addr_ce(addr_ce), .addr_clr(addr_clr),
        .rd_addr(fb_addr), .rd_data(fb_data));

    task automatic cmp(input string req, input string note, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, note, act, exp);
        end
    endtask

    // driver: apply one cycle of stimulus and push the model's post-edge view
    task automatic step(input logic r, input logic c, input logic cl, input logic w,
                        input logic [AW-1:0] wa, input logic [DW-1:0] wd,
                        input logic [AW-1:0] da, input string note);
        exp_t          it;
        logic [AW-1:0] na;
        string         tag;
        @(negedge clk);
        rst_n = r; addr_ce = c; addr_clr = cl; wr_en = w;
        wr_addr = wa; wr_data = wd; addr_d = da;
        na = !r ? CV : (c ? (cl ? CV : da) : aref);
        if (!r)                          tag = "R1";
        else if (c && cl)                tag = "R3";
        else if (c && w && wa == na)     tag = "R6";
        else if (!c && w && wa == aref)  tag = "R7";
        else if (!c)                     tag = "R4";
        else                             tag = "R2";
        if (w) begin                     // R10: writes land during reset too
            mref[wa]  = wd;
            known[wa] = 1'b1;
        end
        it.a = na; it.d = mref[na]; it.chk = known[na]; it.tag = tag; it.note = note;
        exp_q.push_back(it);
        aref = na;
    endtask

    // monitor
    initial begin
        forever begin
            exp_t it;
            @(posedge clk);
            #(CLK_PERIOD/4);
            if (exp_q.size() > 0) begin
                it = exp_q.pop_front();
                cmp(it.tag, it.note, int'(rd_addr), int'(it.a));
                cmp("R8", it.note, int'(fb_addr), int'(it.a));
                if (it.chk) begin
                    cmp({"R5/", it.tag}, it.note, int'(rd_data), int'(it.d));
                    cmp({"R8/", it.tag}, it.note, int'(fb_data), int'(it.d));
                end
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 200000);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=running expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        for (int i = 0; i < DEPTH; i++) begin mref[i] = '0; known[i] = 1'b0; end
        aref = '0;
        rst_n = 1'b0; wr_en = 1'b0; addr_ce = 1'b0; addr_clr = 1'b0;
        wr_addr = '0; wr_data = '0; addr_d = '0;
        step(0, 0, 0, 0, 0, 0, 0, "reset state");
        // R10: fill the array while reset is held
        for (int i = 0; i < DEPTH; i++) step(0, 0, 0, 1, AW'(i), DW'(8'h30 + i), 0, "fill under reset");
        step(1, 0, 0, 0, 0, 0, 4'h3, "stall after reset");
        step(1, 1, 0, 0, 0, 0, 4'h3, "load 3");
        step(1, 1, 0, 0, 0, 0, 4'h5, "load 5");
        step(1, 1, 1, 0, 0, 0, 4'h5, "clear mixed bits");
        step(1, 1, 0, 0, 0, 0, 4'h5, "load 5 again");
        step(1, 0, 1, 0, 0, 0, 4'h0, "clear ignored while stalled");
        step(1, 0, 0, 1, 4'h5, 8'hA5, 4'h0, "stall write to held");
        step(1, 0, 0, 0, 4'h5, 8'h11, 4'h0, "R9 strobe low to held");
        step(1, 1, 0, 0, 0, 0, 4'h5, "R9 reload after dead write");
        step(1, 1, 0, 1, 4'h9, 8'h99, 4'h9, "load with same-edge write");
        step(1, 1, 0, 1, 4'h2, 8'h22, 4'hF, "load with other write");
        step(1, 1, 1, 0, 0, 0, 4'hF, "clear back to CV");
        for (int n = 0; n < 800; n++) begin
            logic          r, c, cl, w;
            logic [AW-1:0] wa, da;
            r  = ($urandom_range(0, 49) != 0);
            c  = ($urandom_range(0, 3) != 0);
            cl = ($urandom_range(0, 9) == 0);
            w  = ($urandom_range(0, 1) == 1);
            da = AW'($urandom);
            wa = ($urandom_range(0, 2) == 0) ? (c ? da : aref) : AW'($urandom);
            step(r, c, cl, w, wa, DW'($urandom), da, "random");
        end
        step(1, 0, 0, 0, 0, 0, 0, "drain");
        repeat (4) @(negedge clk);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule